// File: doc/BRIEF.md
# Flash Query Table Responder

This block supplies the read data of a parallel NOR flash while the array is in query mode. A host read is reduced to a table index. The block then returns one byte of the query table. That byte is either a fixed identification character or a geometry value. Geometry values are worked out from the erase-region settings that the surrounding flash model presents on its inputs.

Up to four erase regions can be described. Each region is given as a sector count and a sector length in 256-byte units. Regions are counted as active up to the first one whose count is zero. Every geometry byte (the region count, the per-region descriptors and the device size exponent) is computed combinationally from those settings.

The selected byte is registered once. It appears on the data output one clock after the address, copied into every byte lane of the configured bus width. Outside query mode the output is zero.

Top module: `cfi_query_responder`

## Requirements
- R1: Table indices 0x10, 0x11 and 0x12 return the ASCII bytes 0x51 ('Q'), 0x52 ('R') and 0x59 ('Y').
- R2: Index 0x2C returns the number of active regions. Region i is active when its sector count and the counts of all lower regions are non-zero.
- R3: For region i, the four indices starting at 0x2D + 4*i return, in order: (count-1) bits 7:0, (count-1) bits 15:8, the length in 256-byte units bits 7:0, and the length bits 15:8.
- R4: Descriptor indices of an inactive region return 0x00. So does every index not named in R1, R2, R3, R5 or R6.
- R5: Index 0x27 returns 8 + floor(log2(S)), where S is the sum of count*length-units over the active regions. It returns 0x00 when S is zero.
- R6: Indices 0x40, 0x41 and 0x42 return 'P' (0x50), 'R' (0x52) and 'I' (0x49). All region descriptors end below index 0x40.
- R7: The table index is the byte address shifted right by 0 (width code 0, 8-bit), by 1 (code 1, 16-bit) or by 2 (code 2 or 3, 32-bit). The discarded low address bits have no effect.
- R8: The output byte b is placed as {24'h0,b} for 8-bit, {16'h0,b,b} for 16-bit and {b,b,b,b} for 32-bit.
- R9: The output is registered. It reflects the inputs sampled at the previous rising clock edge, is zero while query mode is low, and is zero during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| queryMode | input | 1 | High while the flash is in query mode |
| busWidth | input | 2 | Bus width code: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| addr | input | ADDR_W (12) | Byte address of the read |
| regionCount | input | NUM_REGIONS*16 (64) | Sector count of each region, region 0 in the low 16 bits |
| regionUnit | input | NUM_REGIONS*16 (64) | Sector length of each region in 256-byte units, region 0 in the low 16 bits |
| qryData | output | 32 | Replicated table byte |

## Verification
The bench builds the block with its defaults: four regions and a 12-bit address. With those values every table index from 0x00 through 0x47 is reachable at all three bus widths, so the whole table is swept for each width. It does this for four region settings: a large-sectors-first layout, its mirror image, a single region whose count has a non-zero high byte, and a layout with a zero-count hole that must cut off the regions after it. With query mode low, the same sweep shows that the output stays at zero.

// File: rtl/cfi_pkg.sv
package cfi_pkg;
  localparam int MAX_REGIONS = 4;

  typedef enum logic [1:0] {
    BW8   = 2'd0,
    BW16  = 2'd1,
    BW32  = 2'd2,
    BW32X = 2'd3
  } bus_width_e;

  typedef struct packed {
    logic       active;
    bus_width_e width;
    logic       selSig;
    logic       selPri;
    logic       selCount;
    logic       selSize;
    logic       selRegion;
    logic [1:0] charIdx;
    logic [1:0] regionIdx;
    logic [1:0] fieldIdx;
  } cfi_strobe_t;
endpackage

// File: rtl/cfi_ctrl.sv
module cfi_ctrl
  import cfi_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int NUM_REGIONS = 4
) (
  input  logic              queryMode,
  input  logic [1:0]        busWidth,
  input  logic [ADDR_W-1:0] addr,
  output cfi_strobe_t       strb
);
  localparam logic [ADDR_W-1:0] SIG_BASE = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] SIZE_IDX = ADDR_W'(8'h27);
  localparam logic [ADDR_W-1:0] CNT_IDX  = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] REG_BASE = ADDR_W'(8'h2D);
  localparam logic [ADDR_W-1:0] REG_END  = ADDR_W'(8'h2D + 4 * NUM_REGIONS);
  localparam logic [ADDR_W-1:0] PRI_BASE = ADDR_W'(8'h40);

  bus_width_e        width;
  logic [ADDR_W-1:0] idx;
  logic [ADDR_W-1:0] sigOff;
  logic [ADDR_W-1:0] regOff;
  logic [ADDR_W-1:0] priOff;

  always_comb begin
    width = bus_width_e'(busWidth);
    case (width)
      BW8:     idx = addr;
      BW16:    idx = addr >> 1;
      default: idx = addr >> 2;
    endcase
    sigOff = idx - SIG_BASE;
    regOff = idx - REG_BASE;
    priOff = idx - PRI_BASE;

    strb           = '0;
    strb.width     = width;
    strb.active    = queryMode;
    strb.charIdx   = sigOff[1:0];
    strb.regionIdx = regOff[3:2];
    strb.fieldIdx  = regOff[1:0];
    if (queryMode) begin
      strb.selSig    = (idx >= SIG_BASE) && (idx < SIG_BASE + ADDR_W'(3));
      strb.selSize   = (idx == SIZE_IDX);
      strb.selCount  = (idx == CNT_IDX);
      strb.selRegion = (idx >= REG_BASE) && (idx < REG_END);
      strb.selPri    = (idx >= PRI_BASE) && (idx < PRI_BASE + ADDR_W'(3));
      if (strb.selPri) strb.charIdx = priOff[1:0];
    end
  end
endmodule

// File: rtl/cfi_datapath.sv
module cfi_datapath
  import cfi_pkg::*;
#(
  parameter int NUM_REGIONS = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  cfi_strobe_t               strb,
  input  logic [NUM_REGIONS*16-1:0] regionCount,
  input  logic [NUM_REGIONS*16-1:0] regionUnit,
  output logic [31:0]               qryData
);
  localparam int SUM_W = 32 + $clog2(NUM_REGIONS + 1);

  logic [NUM_REGIONS-1:0] regActive;
  logic [15:0]            cntM1   [NUM_REGIONS];
  logic [15:0]            unitVal [NUM_REGIONS];
  logic [SUM_W-1:0]       totalUnits;
  logic [7:0]             sizeLog2;
  logic [7:0]             activeCount;
  logic [7:0]             tblByte;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    logic [15:0] cnt;
    assign cnt        = regionCount[i*16 +: 16];
    assign unitVal[i] = regionUnit[i*16 +: 16];
    assign cntM1[i]   = cnt - 16'd1;
    if (i == 0) begin : g_first
      assign regActive[i] = (cnt != 16'd0);
    end else begin : g_rest
      assign regActive[i] = regActive[i-1] && (cnt != 16'd0);
    end
  end

  always_comb begin
    totalUnits = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (regActive[i])
        totalUnits = totalUnits + SUM_W'(regionCount[i*16 +: 16] * regionUnit[i*16 +: 16]);
    end
    sizeLog2 = 8'd0;
    for (int b = 0; b < SUM_W; b++) begin
      if (totalUnits[b]) sizeLog2 = 8'(b + 8);
    end
    activeCount = 8'($countones(regActive));
  end

  always_comb begin
    tblByte = 8'h00;
    if (strb.selSig) begin
      case (strb.charIdx)
        2'd0:    tblByte = 8'h51;
        2'd1:    tblByte = 8'h52;
        default: tblByte = 8'h59;
      endcase
    end else if (strb.selPri) begin
      case (strb.charIdx)
        2'd0:    tblByte = 8'h50;
        2'd1:    tblByte = 8'h52;
        default: tblByte = 8'h49;
      endcase
    end else if (strb.selCount) begin
      tblByte = activeCount;
    end else if (strb.selSize) begin
      tblByte = sizeLog2;
    end else if (strb.selRegion) begin
      for (int i = 0; i < NUM_REGIONS; i++) begin
        if (strb.regionIdx == 2'(i) && regActive[i]) begin
          case (strb.fieldIdx)
            2'd0:    tblByte = cntM1[i][7:0];
            2'd1:    tblByte = cntM1[i][15:8];
            2'd2:    tblByte = unitVal[i][7:0];
            default: tblByte = unitVal[i][15:8];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qryData <= '0;
    end else if (!strb.active) begin
      qryData <= '0;
    end else begin
      case (strb.width)
        BW8:     qryData <= {24'h0, tblByte};
        BW16:    qryData <= {16'h0, tblByte, tblByte};
        default: qryData <= {4{tblByte}};
      endcase
    end
  end

  // R9: leaving query mode clears the output on the next edge
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !strb.active |=> qryData == 32'h0);
  // R8: narrow bus keeps upper lanes clear
  a_r8_narrow_lanes: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && strb.width == BW8) |=> qryData[31:8] == 24'h0);
  // R8: half-width bus duplicates into two lanes only
  a_r8_half_lanes: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && strb.width == BW16) |=>
      (qryData[31:16] == 16'h0 && qryData[15:8] == qryData[7:0]));
  // R8: full-width bus has all lanes equal
  a_r8_wide_lanes: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && (strb.width == BW32 || strb.width == BW32X)) |=>
      (qryData[31:16] == qryData[15:0] && qryData[15:8] == qryData[7:0]));
  // R2: region count never exceeds the configured maximum
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    strb.selCount |=> qryData[7:0] <= 8'(NUM_REGIONS));
  // R4: descriptor of an inactive region reads as zero
  a_r4_inactive_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.selRegion && !regActive[strb.regionIdx]) |=> qryData == 32'h0);
endmodule

// File: rtl/cfi_query_responder.sv
module cfi_query_responder
  import cfi_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int NUM_REGIONS = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      queryMode,
  input  logic [1:0]                busWidth,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [NUM_REGIONS*16-1:0] regionCount,
  input  logic [NUM_REGIONS*16-1:0] regionUnit,
  output logic [31:0]               qryData
);
  cfi_strobe_t strb;

  cfi_ctrl #(.ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS)) u_ctrl (
    .queryMode (queryMode),
    .busWidth  (busWidth),
    .addr      (addr),
    .strb      (strb)
  );

  cfi_datapath #(.NUM_REGIONS(NUM_REGIONS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .regionCount (regionCount),
    .regionUnit  (regionUnit),
    .qryData     (qryData)
  );
endmodule

// File: tb/sim_cfi_query_responder.sv
module sim_cfi_query_responder;
  localparam int ADDR_W = 12;
  localparam int NR     = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              queryMode = 1'b0;
  logic [1:0]        busWidth = 2'd0;
  logic [ADDR_W-1:0] addr = '0;
  logic [NR*16-1:0]  regionCount = '0;
  logic [NR*16-1:0]  regionUnit = '0;
  logic [31:0]       qryData;

  int nChecks = 0;
  int nFail   = 0;
  int cCnt [NR];
  int cUnit[NR];

  always #10 clk = ~clk;

  cfi_query_responder #(.ADDR_W(ADDR_W), .NUM_REGIONS(NR)) u0 (
    .clk(clk), .rstN(rstN), .queryMode(queryMode), .busWidth(busWidth),
    .addr(addr), .regionCount(regionCount), .regionUnit(regionUnit),
    .qryData(qryData)
  );

  function automatic int expByte(int idx);
    int n = 0;
    longint s = 0;
    int lg = 0;
    while (n < NR && cCnt[n] != 0) n++;
    for (int i = 0; i < n; i++) s += longint'(cCnt[i]) * cUnit[i];
    if (s > 0) begin
      lg = 8;
      while (s > 1) begin s = s / 2; lg++; end
    end
    if (idx == 'h10) return 'h51;
    if (idx == 'h11) return 'h52;
    if (idx == 'h12) return 'h59;
    if (idx == 'h40) return 'h50;
    if (idx == 'h41) return 'h52;
    if (idx == 'h42) return 'h49;
    if (idx == 'h27) return lg;
    if (idx == 'h2C) return n;
    if (idx >= 'h2D && idx < 'h2D + 4 * NR) begin
      int r = (idx - 'h2D) / 4;
      int f = (idx - 'h2D) % 4;
      if (r >= n) return 0;
      case (f)
        0: return (cCnt[r] - 1) & 'hFF;
        1: return ((cCnt[r] - 1) >> 8) & 'hFF;
        2: return cUnit[r] & 'hFF;
        default: return (cUnit[r] >> 8) & 'hFF;
      endcase
    end
    return 0;
  endfunction

  function automatic logic [31:0] placeByte(int w, int b);
    logic [7:0] v = 8'(b);
    if (w == 0) return {24'h0, v};
    if (w == 1) return {16'h0, v, v};
    return {v, v, v, v};
  endfunction

  task automatic check(string req, logic [31:0] exp);
    nChecks++;
    if (qryData !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, qryData, exp);
    end
  endtask

  task automatic loadCfg(int c0, int c1, int c2, int c3, int u0v, int u1, int u2, int u3);
    cCnt[0] = c0; cCnt[1] = c1; cCnt[2] = c2; cCnt[3] = c3;
    cUnit[0] = u0v; cUnit[1] = u1; cUnit[2] = u2; cUnit[3] = u3;
    for (int i = 0; i < NR; i++) begin
      regionCount[i*16 +: 16] = 16'(cCnt[i]);
      regionUnit[i*16 +: 16]  = 16'(cUnit[i]);
    end
  endtask

  // Sweep the table for all widths; low address bits carry junk (R7)
  task automatic sweep(bit qm);
    for (int w = 0; w < 3; w++) begin
      for (int idx = 0; idx < 'h48; idx++) begin
        int junk = idx % (1 << w);
        @(negedge clk);
        queryMode = qm;
        busWidth  = 2'(w);
        addr      = ADDR_W'((idx << w) | junk);
        @(negedge clk);
        if (!qm) check("R9 idle", 32'h0);
        else if (idx >= 'h10 && idx <= 'h12) check("R1/R8 signature", placeByte(w, expByte(idx)));
        else if (idx == 'h2C) check("R2 count", placeByte(w, expByte(idx)));
        else if (idx == 'h27) check("R5 size", placeByte(w, expByte(idx)));
        else if (idx >= 'h40) check("R6 primary", placeByte(w, expByte(idx)));
        else if (idx >= 'h2D && idx < 'h3D) check("R3/R4 descriptor", placeByte(w, expByte(idx)));
        else check("R4/R7 empty", placeByte(w, expByte(idx)));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    loadCfg(15, 1, 2, 1, 'h100, 'h80, 'h20, 'h40);
    queryMode = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 reset", 32'h0);
    rstN = 1'b1;
    sweep(1'b1);
    loadCfg(1, 2, 1, 15, 'h40, 'h20, 'h80, 'h100);
    sweep(1'b1);
    loadCfg(300, 0, 0, 0, 'h140, 0, 0, 0);
    sweep(1'b1);
    loadCfg(4, 0, 3, 2, 'h10, 'h20, 'h20, 'h40);
    sweep(1'b1);
    sweep(1'b0);
    // R9: one-cycle latency, value follows the newly sampled address
    @(negedge clk);
    queryMode = 1'b1; busWidth = 2'd2; addr = ADDR_W'('h10 << 2);
    @(negedge clk);
    addr = ADDR_W'('h11 << 2);
    check("R9 latency", {4{8'h51}});
    @(negedge clk);
    check("R9 latency", {4{8'h52}});
    // R7: width code 3 behaves as 32-bit
    busWidth = 2'd3; addr = ADDR_W'(('h12 << 2) | 3);
    @(negedge clk);
    check("R7 code3", {4{8'h59}});
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule